// File: doc/BRIEF.md
# Dual-Mode Serial Character Delivery Interface

This block receives an already-demodulated asynchronous bit stream at a nominal 1200 baud. It frames the characters in that stream and hands each 8-bit character to a host over three wires: a data line, a bit clock and a word-ready strobe. A single mode input chooses between two ways of delivering the character.

With the mode input low, the block acts as a clock source. The received line is forwarded unchanged to the data output. The block then produces exactly eight clock pulses per character, each rising in the middle of a data bit, and a ready strobe once the frame is complete. With the mode input high, the block captures each good character into a shift register and raises the ready flag. The host then clocks the bits out, least significant first, with its own clock pulses.

Bit timing is derived from the system clock. A prescaler produces a tick at sixteen times the baud rate, and all sampling is done on those ticks. The interface has no valid/ready handshake and cannot apply back-pressure. In the host-clocked mode, a new character overwrites an unread one. In the self-clocked mode, the host must accept every pulse burst as it comes.

Top module: `serial_word_extractor`

## Requirements
- R1: While reset is held and just after it, dclk_o, dr_o and frame_err_o are 0, dclk_oe_o is 1 with mode_i low, and data_o follows rx_i.
- R2: A character is a 0 start bit, then 8 data bits with the least significant bit first, then a stop bit at 1. In mode 0, the bits on data_o at the eight rising edges of dclk_o, taken LSB first, equal the character that was sent.
- R3: A start bit is accepted only if rx_i is still low at the middle of the start bit, which is 8 ticks after the low level is first seen. A shorter low pulse produces no clock pulse, no ready strobe and no error pulse.
- R4: In mode 0, data_o equals rx_i combinationally, with no register in the path.
- R5: In mode 0, dclk_o rises exactly 8 times per frame. Each rise comes one system clock after the tick at a data-bit centre: 24+16·i ticks after the start was detected, for i=0..7. Each pulse stays high for HIGH_TICKS ticks. No pulse is produced for the start or stop bit, and dclk_o is low when dr_o rises.
- R6: In mode 0, dr_o rises one clock after the stop-bit sample (152 ticks after start detection) and stays high for DR_HOLD system clocks.
- R7: One stop bit is enough. Mark runs of 1 to 20 or more bits between characters are treated as idle, and every character in such a stream is delivered.
- R8: If the stop sample is 0, frame_err_o pulses high for exactly one clock. No ready strobe follows, and in mode 1 no byte is loaded, so dr_o stays 0.
- R9: In mode 1, dclk_oe_o and dclk_o are 0. After a good frame, dr_o is 1 and data_o shows bit 0 of the character.
- R10: In mode 1, each rising edge of dclk_i, after a two-flop synchroniser, moves data_o to the next bit. The eighth rising edge drops dr_o.
- R11: Characters sent with a bit period about 3% longer or shorter than nominal are still delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: block drives the bit clock; 1: host drives the bit clock |
| rx_i | input | 1 | Demodulated serial bit stream, idle high |
| dclk_i | input | 1 | Host bit clock (used in mode 1) |
| data_o | output | 1 | Raw line in mode 0, shifted character bit in mode 1 |
| dclk_o | output | 1 | Generated bit clock (mode 0) |
| dclk_oe_o | output | 1 | High when dclk_o should drive the shared clock wire |
| dr_o | output | 1 | Word-end strobe (mode 0) or byte-ready flag (mode 1) |
| frame_err_o | output | 1 | One-clock pulse when a stop bit is sampled low |

## Verification
The line input reaches the sampling logic through two synchroniser flops. Sampling happens on prescaler ticks. A DCLK rise or a DR rise therefore appears one system clock after the tick at which the bit centre or stop centre is sampled. A host clock edge changes data_o two clocks after it is seen on dclk_i. The bench's reference model counts the same ticks from its own copy of the input history and predicts each output for every cycle. It compares them half a period after each edge, away from the active edge. Transaction checks are made separately: bytes rebuilt from the generated pulses, and bytes read back with host pulses. Each of these is made only once its delay has fully elapsed.

// File: rtl/sx_pkg.sv
package sx_pkg;
  typedef enum logic [1:0] {
    SX_IDLE  = 2'd0,
    SX_START = 2'd1,
    SX_DATA  = 2'd2,
    SX_STOP  = 2'd3
  } sx_state_e;
endpackage

// File: rtl/sx_tick_gen.sv
module sx_tick_gen #(
  parameter int CLK_DIV = 10417
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sx_frame_rx.sv
module sx_frame_rx
  import sx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              bit_stb_o,
  output logic              done_stb_o,
  output logic              err_stb_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int OW = $clog2(OVS);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OW-1:0] MID  = OW'(OVS / 2 - 1);
  localparam logic [OW-1:0] LAST = OW'(OVS - 1);
  localparam logic [IW-1:0] TOP  = IW'(DATA_W - 1);

  logic              rx_m, rx_s;
  sx_state_e         st;
  logic [OW-1:0]     ov;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  assign at_last = tick_i && (ov == LAST);

  always_comb begin
    bit_stb_o  = (st == SX_DATA) && at_last;
    done_stb_o = (st == SX_STOP) && at_last && rx_s;
    err_stb_o  = (st == SX_STOP) && at_last && !rx_s;
  end

  assign byte_o = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SX_IDLE;
      ov    <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (tick_i) begin
      unique case (st)
        SX_IDLE: begin
          if (!rx_s) begin
            st <= SX_START;
            ov <= '0;
          end
        end
        SX_START: begin
          if (ov == MID) begin
            ov  <= '0;
            idx <= '0;
            st  <= rx_s ? SX_IDLE : SX_DATA;
          end else begin
            ov <= ov + 1'b1;
          end
        end
        SX_DATA: begin
          if (ov == LAST) begin
            ov    <= '0;
            shreg <= {rx_s, shreg[DATA_W-1:1]};
            if (idx == TOP) st <= SX_STOP;
            else            idx <= idx + 1'b1;
          end else begin
            ov <= ov + 1'b1;
          end
        end
        SX_STOP: begin
          if (ov == LAST) begin
            ov <= '0;
            st <= SX_IDLE;
          end else begin
            ov <= ov + 1'b1;
          end
        end
        default: st <= SX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sx_burst_gen.sv
module sx_burst_gen #(
  parameter int HIGH_TICKS = 8,
  parameter int DR_HOLD    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic bit_stb_i,
  input  logic done_stb_i,
  output logic dclk_o,
  output logic dr_o
);
  localparam int HW = $clog2(HIGH_TICKS + 1);
  localparam int DW = $clog2(DR_HOLD + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HIGH_TICKS - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DR_HOLD - 1);

  logic [HW-1:0] hcnt;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_o <= 1'b0;
      hcnt   <= '0;
    end else if (bit_stb_i) begin
      dclk_o <= 1'b1;
      hcnt   <= '0;
    end else if (dclk_o && tick_i) begin
      if (hcnt == H_LAST) dclk_o <= 1'b0;
      else                hcnt   <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_o <= 1'b0;
      dcnt <= '0;
    end else if (done_stb_i) begin
      dr_o <= 1'b1;
      dcnt <= '0;
    end else if (dr_o) begin
      if (dcnt == D_LAST) dr_o <= 1'b0;
      else                dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/sx_host_shift.sv
module sx_host_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              dclk_i,
  output logic              bit_o,
  output logic              ready_o,
  output logic              rise_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] C_LAST = CW'(DATA_W - 1);

  logic [2:0]        hs;
  logic [DATA_W-1:0] sreg;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs <= '0;
    else        hs <= {hs[1:0], dclk_i};
  end

  assign rise_o = hs[1] & ~hs[2];
  assign bit_o  = sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (load_i) begin
      sreg    <= byte_i;
      cnt     <= '0;
      ready_o <= 1'b1;
    end else if (rise_o && ready_o) begin
      sreg <= sreg >> 1;
      if (cnt == C_LAST) ready_o <= 1'b0;
      else               cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_word_extractor.sv
module serial_word_extractor #(
  parameter int CLK_DIV    = 10417,
  parameter int OVS        = 16,
  parameter int DATA_W     = 8,
  parameter int HIGH_TICKS = 8,
  parameter int DR_HOLD    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic rx_i,
  input  logic dclk_i,
  output logic data_o,
  output logic dclk_o,
  output logic dclk_oe_o,
  output logic dr_o,
  output logic frame_err_o
);
  logic              tick;
  logic              bit_stb, done_stb, err_stb;
  logic [DATA_W-1:0] rx_byte;
  logic              gen_dclk, gen_dr;
  logic              host_bit, host_rdy, host_rise;
  logic              err_q;

  sx_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  sx_frame_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
    .bit_stb_o(bit_stb), .done_stb_o(done_stb), .err_stb_o(err_stb),
    .byte_o(rx_byte)
  );

  sx_burst_gen #(.HIGH_TICKS(HIGH_TICKS), .DR_HOLD(DR_HOLD)) u_burst (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bit_stb_i(bit_stb & ~mode_i), .done_stb_i(done_stb & ~mode_i),
    .dclk_o(gen_dclk), .dr_o(gen_dr)
  );

  sx_host_shift #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .load_i(done_stb & mode_i), .byte_i(rx_byte),
    .dclk_i(dclk_i), .bit_o(host_bit), .ready_o(host_rdy), .rise_o(host_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_stb;
  end

  assign data_o      = mode_i ? host_bit : rx_i;
  assign dclk_o      = gen_dclk;
  assign dclk_oe_o   = ~mode_i;
  assign dr_o        = mode_i ? host_rdy : gen_dr;
  assign frame_err_o = err_q;
endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int CLK_DIV    = 2,
  parameter int HIGH_TICKS = 8,
  parameter int DR_HOLD    = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic dclk_o,
  input logic dr_o,
  input logic frame_err_o,
  input logic host_rise
);
  assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

  assert_no_dr_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !$rose(dr_o));

  assert_dr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (DR_HOLD > 1 && !mode_i && $past(!mode_i) && $rose(dr_o)) |=> dr_o);

  assert_dclk_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (HIGH_TICKS * CLK_DIV > 1 && !mode_i && $rose(dclk_o)) |=> dclk_o);

  assert_dclk_low_at_dr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && $past(!mode_i) && $rose(dr_o)) |-> !dclk_o);

  assert_dr_drop_by_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && $past(mode_i) && $fell(dr_o)) |-> $past(host_rise));
endmodule

bind serial_word_extractor sx_checker #(
  .CLK_DIV(CLK_DIV), .HIGH_TICKS(HIGH_TICKS), .DR_HOLD(DR_HOLD)
) u_sx_checker (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dclk_o(dclk_o), .dr_o(dr_o),
  .frame_err_o(frame_err_o), .host_rise(host_rise)
);

// File: tb/serial_word_extractor_bench.sv
`timescale 1ns/1ps
module serial_word_extractor_bench;
  localparam int DIV   = 2;
  localparam int OVS   = 16;
  localparam int HIGHT = 8;
  localparam int HOLD  = 6;
  localparam int BL    = DIV * OVS;
  localparam int MIDT  = OVS / 2;
  localparam int STOPT = OVS / 2 + OVS * 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic rx = 1'b1;
  logic hclk = 1'b0;
  logic data_o, dclk_o, dclk_oe_o, dr_o, frame_err_o;

  always #2.5 clk = ~clk;

  serial_word_extractor #(
    .CLK_DIV(DIV), .OVS(OVS), .DATA_W(8), .HIGH_TICKS(HIGHT), .DR_HOLD(HOLD)
  ) u_serial_word_extractor (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_i(rx), .dclk_i(hclk),
    .data_o(data_o), .dclk_o(dclk_o), .dclk_oe_o(dclk_oe_o), .dr_o(dr_o),
    .frame_err_o(frame_err_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  int   cyc, n, dclk_left, dr_left;
  bit   active;
  logic h1, h2, m_dclk, m_dr, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; n = 0; active = 0; h1 = 1; h2 = 1;
      m_dclk = 0; m_dr = 0; m_err = 0; dclk_left = 0; dr_left = 0;
    end else begin
      logic rxs;
      bit   tk;
      rxs = h2; h2 = h1; h1 = rx;
      tk = ((cyc % DIV) == DIV - 1);
      cyc++;
      m_err = 0;
      if (m_dr) begin
        dr_left--;
        if (dr_left == 0) m_dr = 0;
      end
      if (tk) begin
        if (m_dclk) begin
          dclk_left--;
          if (dclk_left == 0) m_dclk = 0;
        end
        if (!active) begin
          if (!rxs) begin active = 1; n = 0; end
        end else begin
          n++;
          if (n == MIDT) begin
            if (rxs) active = 0;
          end else if (n >= MIDT + OVS && n < STOPT && ((n - MIDT) % OVS) == 0) begin
            if (!mode) begin m_dclk = 1; dclk_left = HIGHT; end
          end else if (n == STOPT) begin
            if (rxs) begin
              if (!mode) begin m_dr = 1; dr_left = HOLD; end
            end else m_err = 1;
            active = 0;
          end
        end
      end
    end
  end

  // per-cycle comparison and transaction capture, at the falling edge
  logic [7:0] exp_q[$];
  logic [7:0] cap;
  int   capn = 0, dr_seen = 0, err_seen = 0;
  logic p_dclk = 0, p_dr = 0, p_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(frame_err_o == m_err, "R8 err pulse", frame_err_o, m_err);
      if (!mode) begin
        chk(dclk_o == m_dclk, "R5 dclk timing", dclk_o, m_dclk);
        chk(dr_o == m_dr, "R6 dr timing", dr_o, m_dr);
        chk(data_o == rx, "R4 data passthrough", data_o, rx);
        chk(dclk_oe_o == 1'b1, "R9 oe in mode0", dclk_oe_o, 1);
        if (dclk_o && !p_dclk) begin
          cap = {data_o, cap[7:1]};
          capn++;
        end
        if (dr_o && !p_dr) begin
          dr_seen++;
          chk(capn == 8, "R5 pulses per frame", capn, 8);
          if (exp_q.size() == 0) chk(0, "R2 unexpected word", cap, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(cap == e, "R2 word content", cap, e);
          end
          capn = 0;
        end
      end else begin
        chk(!dclk_o && !dclk_oe_o, "R9 no clock drive in mode1",
            {dclk_o, dclk_oe_o}, 0);
      end
      if (frame_err_o && !p_err) begin
        err_seen++;
        capn = 0;
      end
    end
    p_dclk = dclk_o; p_dr = dr_o; p_err = frame_err_o;
  end

  task automatic send_frame(input logic [7:0] b, input int nstop, input int blen,
                            input logic stop_ok);
    if (!mode && stop_ok) exp_q.push_back(b);
    rx = 1'b0;
    repeat (blen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (blen) @(negedge clk);
    end
    rx = stop_ok;
    repeat (blen) @(negedge clk);
    rx = 1'b1;
    repeat ((nstop - 1) * blen) @(negedge clk);
  endtask

  task automatic host_pulse();
    hclk = 1'b1;
    repeat (4) @(negedge clk);
    hclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int base;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    chk(!dclk_o && !dr_o && !frame_err_o, "R1 reset outputs",
        {dclk_o, dr_o, frame_err_o}, 0);
    chk(dclk_oe_o == 1'b1, "R1 reset oe", dclk_oe_o, 1);
    chk(data_o == 1'b1, "R1 reset data", data_o, 1);
    rst_n = 1'b1;
    repeat (BL) @(negedge clk);

    // R2 / R7: assorted patterns, single and long stop runs
    send_frame(8'h55, 1, BL, 1);
    send_frame(8'h00, 1, BL, 1);
    send_frame(8'hFF, 10, BL, 1);
    repeat (20 * BL) @(negedge clk);
    send_frame(8'h3A, 1, BL, 1);
    repeat (2 * BL) @(negedge clk);
    chk(dr_seen == 4, "R7 idle marks and stop runs", dr_seen, 4);

    // R11: bit period off nominal
    base = dr_seen;
    send_frame(8'h81, 3, BL - 1, 1);
    send_frame(8'h7E, 2, BL + 1, 1);
    repeat (2 * BL) @(negedge clk);
    chk(dr_seen == base + 2, "R11 rate tolerance", dr_seen, base + 2);

    // R3: short low glitch is not a start bit
    base = dr_seen;
    rx = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rx = 1'b1;
    repeat (12 * BL) @(negedge clk);
    chk(capn == 0, "R3 glitch clock pulses", capn, 0);
    chk(dr_seen == base && err_seen == 0, "R3 glitch strobes",
        {dr_seen[15:0], err_seen[15:0]}, {base[15:0], 16'd0});

    // R8: framing error in mode 0, then recovery
    base = dr_seen;
    send_frame(8'hC3, 3, BL, 0);
    chk(err_seen == 1, "R8 error flagged", err_seen, 1);
    chk(dr_seen == base, "R8 no ready on error", dr_seen, base);
    send_frame(8'h96, 2, BL, 1);
    repeat (2 * BL) @(negedge clk);
    chk(dr_seen == base + 1, "R8 recovery", dr_seen, base + 1);
    chk(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);

    // R9 / R10: host-clocked mode
    mode = 1'b1;
    repeat (BL) @(negedge clk);
    b = 8'hA5;
    send_frame(b, 2, BL, 1);
    chk(dr_o == 1'b1, "R9 ready after frame", dr_o, 1);
    chk(data_o == b[0], "R9 lsb first", data_o, b[0]);
    for (int i = 1; i < 8; i++) begin
      host_pulse();
      chk(data_o == b[i], "R10 host shift bit", data_o, b[i]);
      chk(dr_o == 1'b1, "R10 ready held", dr_o, 1);
    end
    host_pulse();
    chk(dr_o == 1'b0, "R10 ready drops on eighth edge", dr_o, 0);

    b = 8'h4C;
    send_frame(b, 2, BL, 1);
    chk(dr_o == 1'b1 && data_o == b[0], "R9 second word", {dr_o, data_o}, {1'b1, b[0]});
    for (int i = 0; i < 8; i++) host_pulse();
    chk(dr_o == 1'b0, "R10 second word drained", dr_o, 0);

    send_frame(8'h3C, 2, BL, 0);
    chk(dr_o == 1'b0, "R8 no load in mode1", dr_o, 0);
    chk(err_seen == 2, "R8 error count", err_seen, 2);

    repeat (BL) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule